// File: doc/BRIEF.md
# 8b/10b Line Encoder with Running Disparity

This block turns a stream of data bytes into DC-balanced 10-bit line symbols. On every cycle that `in_valid` is high, the byte on `in_byte` is encoded and the symbol appears on `out_sym` one clock later, with `out_valid` high. The byte splits into a low five-bit group and a high three-bit group. Each group has its own sub-encoder: a 5b/6b unit and a 3b/4b unit. Their outputs are joined into one symbol. Only data characters are produced. Control characters and decoding are not part of this block.

A two-state machine holds the running disparity of the line. Its states are `RD_NEG` (−1, entered on reset) and `RD_POS` (+1). Each sub-encoder has a table of codes in their negative-disparity form. It sends the bitwise inverse of a code when the disparity is positive and the code is unbalanced. A balancing unit counts the ones and zeros of each code. An unbalanced code fires the `FLIP` transition (NEG↔POS). A balanced code takes the `HOLD` transition. The 3b/4b unit works from the disparity left after the 6-bit group. Cycles with `in_valid` low take the `IDLE` transition, which leaves the state alone.

Top module: `line_encoder_8b10b`

## Requirements
- R1: One cycle after a cycle with `in_valid` high, `out_valid` is high and `out_sym` holds that byte's symbol. One cycle after a cycle with `in_valid` low, `out_valid` is low.
- R2: Reset (`rst_n` low, asynchronous) clears `out_valid` and `out_sym` to zero and puts the running disparity at −1. The first symbol after reset therefore has at least as many ones as zeros.
- R3: Each symbol has 4, 5 or 6 ones. The running disparity, counted from −1 at reset, is exactly ±1 after every 6-bit group and after every 4-bit group.
- R4: Input bit mapping: `in_byte[4:0]` is group EDCBA, with A = bit 0. `in_byte[7:5]` is group HGF, with F = bit 5. Output bit mapping: `out_sym[9:4]` is abcdei, with a = bit 9, the first bit on the line. `out_sym[3:0]` is fghj, with j = bit 0.
- R5: The 6-bit group follows the standard data-character 5b/6b table. Its balanced codes are sent unchanged in either disparity, except code 7 (111000 / 000111). Unbalanced codes are inverted under positive disparity. Example: D.0 is 100111 at −1 and 011000 at +1.
- R6: The 3b/4b group picks its form from the disparity after the 6-bit group. Example: byte 0x00 at −1 gives 1001110100, and at +1 gives 0110001011.
- R7: For HGF = 7, the alternate form is used in two cases: at −1 for EDCBA = 17, 18 or 20 (0111), and at +1 for EDCBA = 11, 13 or 14 (1000). Bits e, i, f, g, h of a symbol are never all equal. Examples: 0xF1 at −1 gives 1000110111, and 0xEB at +1 gives 1101001000.
- R8: Cycles with `in_valid` low leave the running disparity unchanged, whatever is on `in_byte`.
- R9: For a given disparity, no two bytes give the same symbol, and the same byte always gives the same symbol.
- R10: No run of equal bits on the line is longer than five, including runs that cross symbol boundaries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Byte on `in_byte` is to be encoded this cycle |
| in_byte | input | 8 | Data byte, HGF in bits 7:5, EDCBA in bits 4:0 |
| out_valid | output | 1 | `out_sym` carries a new symbol |
| out_sym | output | 10 | Symbol, bit 9 (a) sent first, bit 0 (j) last |

## Verification
Every result is due exactly one rising edge after the cycle that presents the byte. There is one register between `in_byte` and `out_sym`, and the disparity state register updates on the same edge. The bench drives a byte on a falling edge and reads `out_valid` and `out_sym` on the next falling edge, before it drives the next input. The expected disparity for each symbol is the bench's own running sum of the ones and zeros it has seen on the line. The bench sends every byte under both disparities, and puts in a disparity-flipping byte when it needs to switch. Idle cycles and a mid-stream reset are checked on the falling edge right after the edge that should have cleared `out_valid`.

// File: rtl/enc8b10b_pkg.sv
package enc8b10b_pkg;
    localparam int BYTE_W = 8;
    localparam int LO_W   = 5;
    localparam int HI_W   = BYTE_W - LO_W;
    localparam int C6_W   = LO_W + 1;
    localparam int C4_W   = HI_W + 1;
    localparam int SYM_W  = C6_W + C4_W;

    typedef enum logic {
        RD_NEG = 1'b0,
        RD_POS = 1'b1
    } rd_t;

    function automatic rd_t rd_toggle(input rd_t r);
        return (r == RD_NEG) ? RD_POS : RD_NEG;
    endfunction
endpackage

// File: rtl/code_balance.sv
module code_balance #(
    parameter int W = 6
) (
    input  logic [W-1:0] code,
    output logic         neutral
);
    localparam int HALF = W / 2;
    localparam int CW   = $clog2(W + 1);

    logic [CW-1:0] ones;

    always_comb begin
        ones = '0;
        for (int i = 0; i < W; i++) begin
            ones = ones + CW'(code[i]);
        end
        neutral = (ones == CW'(HALF));
    end
endmodule

// File: rtl/enc5b6b.sv
module enc5b6b
    import enc8b10b_pkg::*;
(
    input  logic [LO_W-1:0] grp,
    input  rd_t             rd_in,
    output logic [C6_W-1:0] code,
    output rd_t             rd_out
);
    logic [C6_W-1:0] base;
    logic            neutral;
    logic            invert;

    always_comb begin
        unique case (grp)
            5'd0:  base = 6'b100111;
            5'd1:  base = 6'b011101;
            5'd2:  base = 6'b101101;
            5'd3:  base = 6'b110001;
            5'd4:  base = 6'b110101;
            5'd5:  base = 6'b101001;
            5'd6:  base = 6'b011001;
            5'd7:  base = 6'b111000;
            5'd8:  base = 6'b111001;
            5'd9:  base = 6'b100101;
            5'd10: base = 6'b010101;
            5'd11: base = 6'b110100;
            5'd12: base = 6'b001101;
            5'd13: base = 6'b101100;
            5'd14: base = 6'b011100;
            5'd15: base = 6'b010111;
            5'd16: base = 6'b011011;
            5'd17: base = 6'b100011;
            5'd18: base = 6'b010011;
            5'd19: base = 6'b110010;
            5'd20: base = 6'b001011;
            5'd21: base = 6'b101010;
            5'd22: base = 6'b011010;
            5'd23: base = 6'b111010;
            5'd24: base = 6'b110011;
            5'd25: base = 6'b100110;
            5'd26: base = 6'b010110;
            5'd27: base = 6'b110110;
            5'd28: base = 6'b001110;
            5'd29: base = 6'b101110;
            5'd30: base = 6'b011110;
            default: base = 6'b101011;
        endcase
    end

    code_balance #(.W(C6_W)) u_bal (
        .code    (base),
        .neutral (neutral)
    );

    always_comb begin
        invert = (rd_in == RD_POS) && (!neutral || (grp == 5'd7));
        code   = invert ? ~base : base;
        rd_out = neutral ? rd_in : rd_toggle(rd_in);
    end
endmodule

// File: rtl/enc3b4b.sv
module enc3b4b
    import enc8b10b_pkg::*;
(
    input  logic [HI_W-1:0] grp,
    input  logic [LO_W-1:0] lo_grp,
    input  rd_t             rd_in,
    output logic [C4_W-1:0] code,
    output rd_t             rd_out
);
    logic [C4_W-1:0] base;
    logic            neutral;
    logic            use_alt;
    logic            invert;

    always_comb begin
        if (rd_in == RD_NEG) begin
            use_alt = (lo_grp == 5'd17) || (lo_grp == 5'd18) || (lo_grp == 5'd20);
        end else begin
            use_alt = (lo_grp == 5'd11) || (lo_grp == 5'd13) || (lo_grp == 5'd14);
        end
    end

    always_comb begin
        unique case (grp)
            3'd0:    base = 4'b1011;
            3'd1:    base = 4'b1001;
            3'd2:    base = 4'b0101;
            3'd3:    base = 4'b1100;
            3'd4:    base = 4'b1101;
            3'd5:    base = 4'b1010;
            3'd6:    base = 4'b0110;
            default: base = use_alt ? 4'b0111 : 4'b1110;
        endcase
    end

    code_balance #(.W(C4_W)) u_bal (
        .code    (base),
        .neutral (neutral)
    );

    always_comb begin
        invert = (rd_in == RD_POS) && (!neutral || (grp == 3'd3));
        code   = invert ? ~base : base;
        rd_out = neutral ? rd_in : rd_toggle(rd_in);
    end
endmodule

// File: rtl/line_encoder_8b10b.sv
module line_encoder_8b10b
    import enc8b10b_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    output logic              out_valid,
    output logic [SYM_W-1:0]  out_sym
);
    rd_t             rd_q;
    rd_t             rd_mid;
    rd_t             rd_end;
    rd_t             rd_nxt;
    logic [C6_W-1:0] c6;
    logic [C4_W-1:0] c4;

    enc5b6b u_lo (
        .grp    (in_byte[LO_W-1:0]),
        .rd_in  (rd_q),
        .code   (c6),
        .rd_out (rd_mid)
    );

    enc3b4b u_hi (
        .grp    (in_byte[BYTE_W-1:LO_W]),
        .lo_grp (in_byte[LO_W-1:0]),
        .rd_in  (rd_mid),
        .code   (c4),
        .rd_out (rd_end)
    );

    // Transitions: IDLE (no valid byte), HOLD (symbol balanced), FLIP (unbalanced).
    always_comb begin
        rd_nxt = rd_q;
        unique case (rd_q)
            RD_NEG: if (in_valid) rd_nxt = rd_end;
            RD_POS: if (in_valid) rd_nxt = rd_end;
            default: rd_nxt = RD_NEG;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= RD_NEG;
        end else begin
            rd_q <= rd_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_sym   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_sym <= {c6, c4};
            end
        end
    end
endmodule

// File: rtl/line_encoder_8b10b_checker.sv
module line_encoder_8b10b_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic       out_valid,
    input logic [9:0] out_sym,
    input logic       rd_pos
);
    p_valid_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_rd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(rd_pos));

    p_weight_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($countones(out_sym) >= 4 && $countones(out_sym) <= 6));

    p_neg_heavy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !rd_pos) |=> ($countones(out_sym) >= 5));

    p_pos_light_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && rd_pos) |=> ($countones(out_sym) <= 5));

    p_rd_tracks_weight_r3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ((rd_pos != $past(rd_pos)) == ($countones(out_sym) != 5)));

    p_no_eifgh_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (!(&out_sym[5:1]) && (|out_sym[5:1])));
endmodule

bind line_encoder_8b10b line_encoder_8b10b_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_sym   (out_sym),
    .rd_pos    (rd_q)
);

// File: tb/line_encoder_8b10b_tb.sv
`timescale 1ns/1ps
module line_encoder_8b10b_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic       out_valid;
    logic [9:0] out_sym;

    int checks = 0;
    int failures = 0;
    int rd = -1;
    int run_len = 0;
    logic last_bit = 1'b0;
    bit done = 0;
    int owner [2][1024];
    int sym_of [2][256];

    always #5 clk = ~clk;

    line_encoder_8b10b u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_byte   (in_byte),
        .out_valid (out_valid),
        .out_sym   (out_sym)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d (0x%0h) expected=%0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // Drive one byte, return the symbol observed one edge later; run all line checks.
    task automatic send(input logic [7:0] b, output logic [9:0] s);
        int slot;
        int d;
        int mid;
        slot = (rd < 0) ? 0 : 1;
        in_valid = 1'b1;
        in_byte  = b;
        @(negedge clk);
        in_valid = 1'b0;
        in_byte  = ~b;
        s = out_sym;
        chk(out_valid === 1'b1, "R1 out_valid after valid", int'(out_valid), 1);
        d = 2 * $countones(s) - 10;
        chk((rd < 0) ? (d == 0 || d == 2) : (d == 0 || d == -2), "R3 symbol disparity", d, 0);
        mid = rd + 2 * $countones(s[9:4]) - 6;
        chk(mid == 1 || mid == -1, "R3 disparity after 6-bit group", mid, rd);
        chk(mid + 2 * $countones(s[3:0]) - 4 == rd + d, "R3 disparity after 4-bit group", mid + 2 * $countones(s[3:0]) - 4, rd + d);
        rd = rd + d;
        chk(rd == 1 || rd == -1, "R3 running disparity bound", rd, 1);
        chk(!(&s[5:1]) && (|s[5:1]), "R7 e,i,f,g,h not all equal", int'(s[5:1]), 0);
        for (int i = 9; i >= 0; i--) begin
            if (s[i] == last_bit) run_len++;
            else run_len = 1;
            last_bit = s[i];
            if (run_len > 5) begin
                chk(0, "R10 run length", run_len, 5);
                run_len = 1;
            end
        end
        if (owner[slot][s] >= 0) begin
            chk(owner[slot][s] == int'(b), "R9 symbol unique per disparity", owner[slot][s], int'(b));
        end
        owner[slot][s] = int'(b);
        if (sym_of[slot][b] >= 0) begin
            chk(sym_of[slot][b] == int'(s), "R9 same byte same symbol", int'(s), sym_of[slot][b]);
        end
        sym_of[slot][b] = int'(s);
    endtask

    task automatic force_rd(input int target);
        logic [9:0] s;
        if (rd != target) send(8'h03, s); // D.3.0 always flips the disparity
    endtask

    task automatic spot(input logic [7:0] b, input int at_rd, input logic [9:0] exp, input string req);
        logic [9:0] s;
        force_rd(at_rd);
        send(b, s);
        chk(s == exp, req, int'(s), int'(exp));
    endtask

    initial begin
        #2_000_000;
        chk(0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        logic [9:0] s;
        int rd_before;
        for (int r = 0; r < 2; r++) begin
            for (int i = 0; i < 1024; i++) owner[r][i] = -1;
            for (int i = 0; i < 256; i++) sym_of[r][i] = -1;
        end
        repeat (3) @(negedge clk);
        chk(out_valid === 1'b0, "R2 reset out_valid", int'(out_valid), 0);
        chk(out_sym === 10'd0, "R2 reset out_sym", int'(out_sym), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid === 1'b0, "R1 idle after reset", int'(out_valid), 0);

        // R2: first symbol is formed under negative disparity
        send(8'h00, s);
        chk(s == 10'b1001110100, "R2 first symbol uses RD-", int'(s), int'(10'b1001110100));

        // R4/R5/R6/R7 spot symbols
        spot(8'h00, 1,  10'b0110001011, "R6 D.0.0 at RD+");
        spot(8'hB5, -1, 10'b1010101010, "R4 D.21.5 at RD-");
        spot(8'hB5, 1,  10'b1010101010, "R4 D.21.5 at RD+");
        spot(8'hFF, -1, 10'b1010110001, "R5 D.31.7 at RD-");
        spot(8'hFF, 1,  10'b0101001110, "R5 D.31.7 at RD+");
        spot(8'h67, -1, 10'b1110001100, "R5 D.7.3 at RD-");
        spot(8'h67, 1,  10'b0001110011, "R5 D.7.3 at RD+");
        spot(8'hF1, -1, 10'b1000110111, "R7 D.17.7 at RD- alternate");
        spot(8'hF1, 1,  10'b1000110001, "R7 D.17.7 at RD+ primary");
        spot(8'hEB, 1,  10'b1101001000, "R7 D.11.7 at RD+ alternate");
        spot(8'hEB, -1, 10'b1101001110, "R7 D.11.7 at RD- primary");
        spot(8'h03, -1, 10'b1100011011, "R4 D.3.0 at RD-");

        // R8: idle cycles with a flipping byte on the bus leave disparity alone
        rd_before = rd;
        for (int k = 0; k < 4; k++) begin
            in_valid = 1'b0;
            in_byte  = 8'h03;
            @(negedge clk);
            chk(out_valid === 1'b0, "R8 idle out_valid low", int'(out_valid), 0);
        end
        spot(8'h00, rd_before, (rd_before < 0) ? 10'b1001110100 : 10'b0110001011, "R8 disparity held over idle");

        // R9/R3/R10: every byte under both disparities
        for (int b = 0; b < 256; b++) begin
            for (int t = 0; t < 2; t++) begin
                force_rd(t == 0 ? -1 : 1);
                send(8'(b), s);
            end
        end

        // R2: reset mid-stream returns disparity to -1
        force_rd(1);
        rst_n = 1'b0;
        @(negedge clk);
        chk(out_valid === 1'b0, "R2 mid-stream reset out_valid", int'(out_valid), 0);
        chk(out_sym === 10'd0, "R2 mid-stream reset out_sym", int'(out_sym), 0);
        rst_n = 1'b1;
        rd = -1;
        run_len = 0;
        @(negedge clk);
        send(8'h00, s);
        chk(s == 10'b1001110100, "R2 disparity -1 after reset", int'(s), int'(10'b1001110100));

        finish_run();
    end
endmodule